// File: doc/BRIEF.md
# Memory Block Copy Engine

This engine moves a run of elements from one place in cartridge memory to another while the CPU is kept waiting. A single start pulse carries the element size, the source pointer, the destination address and a stored count value. The engine then reads and writes the elements one at a time through a memory request port and raises a one-clock done pulse when the last write has been accepted.

At the same start, the engine latches how many CPU cycles the bus sequencer has to hold the CPU off. The figure depends only on the count value and not on the element size. If the source or destination is not aligned to the element size, the engine raises an error flag and touches no memory.

The memory request port is a valid/ready stream. Once `mem_req_valid` is high, the address, write flag, size and write data stay unchanged until a cycle in which `mem_req_ready` is also high. Each accepted read must be answered by exactly one `mem_rsp_valid` pulse, with the data in the low bytes of `mem_rsp_rdata`. The engine accepts that response in any cycle, and it has at most one read in flight. Reads are little-endian.

Top module: `blk_copy_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `mem_req_valid` are 0.
- R2: With size code 0 (byte), a start with count value v copies v+1 bytes from the source to the destination.
- R3: With size code 1 (16-bit), a start copies v+1 two-byte elements. Both addresses must be even.
- R4: With size code 2 (32-bit), a start copies v+1 four-byte elements. Both addresses must be multiples of four.
- R5: In each of these cases, a start sets `err` in the next cycle, issues no memory request and gives no `done`:
  - the start has a misaligned address;
  - the start carries size code 3.
  Each later start that the engine accepts clears `err`.
- R6: At every accepted start, `busy_cycles` takes the value 2 + ((v+1) >> 3) in the next cycle, for every size code.
- R7: Element i is read from source + i·size and then written to destination + i·size. The elements go in ascending order, one read and one write at a time. An overlapping forward copy therefore propagates the data it has already written.
- R8: `done` is high for exactly one clock, in the cycle after the final write is accepted. In that same cycle `busy` is low.
- R9: A start pulse while `busy` is high is ignored. Neither the copy in progress nor `busy_cycles` changes.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted when not busy |
| size_code | input | 2 | Element size: 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| src_addr | input | ADDR_W | Source pointer |
| dst_addr | input | ADDR_W | Destination address |
| count_val | input | CNT_W | Stored count value v (v+1 elements) |
| busy | output | 1 | Copy in progress |
| busy_cycles | output | CNT_W | Latched CPU hold-off cycles |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Misaligned or reserved start |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Byte address of element |
| mem_req_size | output | 2 | Element size code |
| mem_req_wdata | output | 32 | Write data, low bytes used |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The bound checker checks the following properties on every cycle:
- the request stays stable under back-pressure;
- `done` is a single-cycle pulse and falls while `busy` is low;
- no request is issued while idle or while `err` is set;
- `busy_cycles` follows the count formula after each accepted start and holds while busy.

Only the bench scenarios can show the following:
- that the right bytes arrive in memory for each size;
- that an overlapping copy propagates in ascending order;
- that writes land at the expected addresses;
- that misaligned starts leave memory untouched.

// File: rtl/bce_pkg.sv
package bce_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } elem_sz_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WAIT = 2'd2,
    ST_WR   = 2'd3
  } cp_state_e;
endpackage

// File: rtl/bce_align_chk.sv
module bce_align_chk
  import bce_pkg::*;
(
  input  elem_sz_e   size,
  input  logic [1:0] src_lo,
  input  logic [1:0] dst_lo,
  output logic       ok
);
  always_comb begin
    case (size)
      SZ_BYTE: ok = 1'b1;
      SZ_HALF: ok = ~src_lo[0] & ~dst_lo[0];
      SZ_WORD: ok = (src_lo == 2'b00) && (dst_lo == 2'b00);
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/bce_busy_calc.sv
module bce_busy_calc #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] count_val,
  output logic [CNT_W-1:0] cycles
);
  localparam int EW = CNT_W + 1;
  logic [EW-1:0] elems;
  logic [EW-1:0] sum;

  always_comb begin
    elems  = {1'b0, count_val} + EW'(1);
    sum    = (elems >> 3) + EW'(2);
    cycles = sum[CNT_W-1:0];
  end
endmodule

// File: rtl/bce_addr_gen.sv
module bce_addr_gen
  import bce_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [CNT_W-1:0]  idx,
  input  elem_sz_e          size,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset  = ADDR_W'(idx) << size;
    rd_addr = src_base + offset;
    wr_addr = dst_base + offset;
  end
endmodule

// File: rtl/blk_copy_engine.sv
module blk_copy_engine
  import bce_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        size_code,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [CNT_W-1:0]  count_val,
  output logic              busy,
  output logic [CNT_W-1:0]  busy_cycles,
  output logic              done,
  output logic              err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata
);
  localparam int DATA_W = 32;

  cp_state_e         state_q;
  elem_sz_e          size_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  last_q, idx_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cyc_q;
  logic              err_q, done_q;

  logic              aligned;
  logic [CNT_W-1:0]  cyc_calc;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              accept;

  bce_align_chk u_align (
    .size   (elem_sz_e'(size_code)),
    .src_lo (src_addr[1:0]),
    .dst_lo (dst_addr[1:0]),
    .ok     (aligned)
  );

  bce_busy_calc #(.CNT_W(CNT_W)) u_busy (
    .count_val (count_val),
    .cycles    (cyc_calc)
  );

  bce_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .src_base (src_q),
    .dst_base (dst_q),
    .idx      (idx_q),
    .size     (size_q),
    .rd_addr  (rd_addr),
    .wr_addr  (wr_addr)
  );

  assign accept = start && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      size_q  <= SZ_BYTE;
      src_q   <= '0;
      dst_q   <= '0;
      last_q  <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      cyc_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cyc_q  <= cyc_calc;
            size_q <= elem_sz_e'(size_code);
            src_q  <= src_addr;
            dst_q  <= dst_addr;
            last_q <= count_val;
            idx_q  <= '0;
            err_q  <= ~aligned;
            if (aligned) state_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            data_q  <= mem_rsp_rdata;
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (mem_req_ready) begin
            if (idx_q == last_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q   <= idx_q + CNT_W'(1);
              state_q <= ST_RD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign busy_cycles   = cyc_q;
  assign done          = done_q;
  assign err           = err_q;
  assign mem_req_valid = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_req_we    = (state_q == ST_WR);
  assign mem_req_addr  = (state_q == ST_WR) ? wr_addr : rd_addr;
  assign mem_req_size  = size_q;
  assign mem_req_wdata = data_q;
endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  count_val,
  input logic              busy,
  input logic [CNT_W-1:0]  busy_cycles,
  input logic              done,
  input logic              err,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [1:0]        mem_req_size,
  input logic [31:0]       mem_req_wdata
);
  logic [CNT_W:0]   n_elems;
  logic [CNT_W-1:0] want_cyc;
  logic             seen_clk;

  always_comb begin
    n_elems  = {1'b0, count_val} + (CNT_W+1)'(1);
    want_cyc = CNT_W'((n_elems >> 3) + (CNT_W+1)'(2));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) seen_clk <= 1'b0;
    else        seen_clk <= 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !err && !mem_req_valid));

  p_err_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mem_req_valid);

  p_busy_formula_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && start && !busy) |=> (busy_cycles == $past(want_cyc)));

  p_req_in_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && busy && $past(busy)) |-> $stable(busy_cycles));

  p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)
       && $stable(mem_req_size) && $stable(mem_req_wdata)));
endmodule

bind blk_copy_engine bce_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .count_val     (count_val),
  .busy          (busy),
  .busy_cycles   (busy_cycles),
  .done          (done),
  .err           (err),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_size  (mem_req_size),
  .mem_req_wdata (mem_req_wdata)
);

// File: tb/blk_copy_engine_tb_top.sv
module blk_copy_engine_tb_top;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        size_code = '0;
  logic [ADDR_W-1:0] src_addr = '0;
  logic [ADDR_W-1:0] dst_addr = '0;
  logic [CNT_W-1:0]  count_val = '0;
  logic              busy, done, err;
  logic [CNT_W-1:0]  busy_cycles;
  logic              mem_req_valid, mem_req_we;
  logic              mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [1:0]        mem_req_size;
  logic [31:0]       mem_req_wdata;
  logic              mem_rsp_valid = 1'b0;
  logic [31:0]       mem_rsp_rdata = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0]  mem     [1024];
  logic [7:0]  exp_mem [1024];
  logic [31:0] wr_log  [256];
  int          wr_n = 0;
  int          req_n = 0;
  int          hold_bad = 0;
  logic        prev_stall = 1'b0;
  logic [ADDR_W-1:0] prev_addr = '0;

  always #4 clk = ~clk;

  blk_copy_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .size_code(size_code),
    .src_addr(src_addr), .dst_addr(dst_addr), .count_val(count_val),
    .busy(busy), .busy_cycles(busy_cycles), .done(done), .err(err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // memory model: random ready, one-cycle read latency, little-endian
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) hold_bad = hold_bad + 1;
    prev_stall = mem_req_valid && !mem_req_ready;
    prev_addr  = mem_req_addr;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      req_n = req_n + 1;
      if (!mem_req_we) begin
        logic [31:0] rd;
        rd = '0;
        for (int b = 0; b < (1 << mem_req_size); b++)
          rd[8*b +: 8] = mem[10'(mem_req_addr + ADDR_W'(b))];
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= rd;
      end else begin
        for (int b = 0; b < (1 << mem_req_size); b++)
          mem[10'(mem_req_addr + ADDR_W'(b))] <= mem_req_wdata[8*b +: 8];
        wr_log[wr_n % 256] = mem_req_addr;
        wr_n = wr_n + 1;
      end
    end
    mem_req_ready <= ($urandom % 4) != 0;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int exp_cycles(input int v);
    return 2 + ((v + 1) >> 3);
  endfunction

  function automatic bit is_aligned(input int sz, input int s, input int d);
    if (sz == 3) return 0;
    return ((s % (1 << sz)) == 0) && ((d % (1 << sz)) == 0);
  endfunction

  function automatic int mem_diff();
    int n = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) n++;
    return n;
  endfunction

  task automatic run_copy(input int sz, input int s, input int d, input int v,
                          input string req, input bit poke_busy);
    bit ok_al;
    int base_wr, base_req, wait_n, step, bad_addr;
    bit got_done;
    ok_al    = is_aligned(sz, s, d);
    step     = (sz == 3) ? 1 : (1 << sz);
    base_wr  = wr_n;
    base_req = req_n;
    @(negedge clk);
    start = 1'b1; size_code = 2'(sz); src_addr = ADDR_W'(s);
    dst_addr = ADDR_W'(d); count_val = CNT_W'(v);
    @(negedge clk);
    start = 1'b0;
    chk(busy_cycles == CNT_W'(exp_cycles(v)), "R6 busy_cycles", busy_cycles, exp_cycles(v));
    chk(err == !ok_al, "R5 err flag", err, !ok_al);
    if (!ok_al) begin
      got_done = 0;
      repeat (10) begin
        @(negedge clk);
        if (done) got_done = 1;
      end
      chk(req_n == base_req, "R5 no request", req_n - base_req, 0);
      chk(!got_done, "R5 no done", got_done, 0);
      chk(mem_diff() == 0, "R5 memory unchanged", mem_diff(), 0);
      return;
    end
    for (int i = 0; i <= v; i++)
      for (int b = 0; b < step; b++)
        exp_mem[(d + i*step + b) % 1024] = exp_mem[(s + i*step + b) % 1024];
    if (poke_busy) begin
      @(negedge clk);
      start = 1'b1; size_code = 2'd0; src_addr = 32'd900;
      dst_addr = 32'd1000; count_val = 8'd200;
      @(negedge clk);
      start = 1'b0;
      chk(busy_cycles == CNT_W'(exp_cycles(v)), "R9 busy_cycles held", busy_cycles, exp_cycles(v));
    end
    wait_n = 0;
    while (!done && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(done == 1'b1, "R8 done seen", done, 1);
    chk(busy == 1'b0, "R8 idle at done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    chk(mem_diff() == 0, req, mem_diff(), 0);
    chk(wr_n - base_wr == v + 1, "R7 write count", wr_n - base_wr, v + 1);
    bad_addr = 0;
    for (int i = 0; i <= v; i++)
      if (wr_log[(base_wr + i) % 256] != 32'(d + i*step)) bad_addr++;
    chk(bad_addr == 0, "R7 ascending write addresses", bad_addr, 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'($urandom);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !mem_req_valid, "R1 reset state",
        {busy, done, err, mem_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req_valid, "R1 idle after reset", busy, 0);

    // directed corners
    run_copy(0, 10, 300, 0, "R2 single byte", 0);
    run_copy(0, 100, 101, 7, "R7 overlapping forward byte copy", 0);
    run_copy(1, 20, 400, 6, "R3 halfword copy", 0);
    run_copy(2, 40, 500, 7, "R4 longword copy boundary v=7", 0);
    run_copy(1, 21, 400, 3, "R5 odd halfword", 0);
    run_copy(2, 42, 500, 3, "R5 longword off by two", 0);
    run_copy(3, 40, 500, 3, "R5 reserved size", 0);
    run_copy(0, 60, 600, 15, "R9 byte copy with start while busy", 1);
    run_copy(0, 5, 700, 255, "R6 max count byte copy", 0);

    // constrained random
    for (int k = 0; k < 24; k++) begin
      int sz, s, d, v;
      sz = $urandom % 3;
      v  = $urandom % 24;
      s  = ($urandom % 200) & ~((1 << sz) - 1);
      d  = (256 + ($urandom % 200)) & ~((1 << sz) - 1);
      if (($urandom % 5) == 0 && sz != 0) s = s + 1;
      run_copy(sz, s, d, v, (sz == 0) ? "R2 random byte" :
                            (sz == 1) ? "R3 random halfword" : "R4 random longword", 0);
    end
    chk(hold_bad == 0, "R10 request held under back-pressure", hold_bad, 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule